// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block forms the result of a two-input single-precision operation once the arithmetic datapath has found that at least one operand is a NaN. It classifies each operand as quiet NaN, signaling NaN or neither. It picks one operand under one of three static priority schemes and quiets that operand before it leaves the block. A default-NaN mode replaces the chosen operand with a fixed default pattern. The classifier treats a NaN as quiet when the top fraction bit (bit 22) is 1, and as signaling when that bit is 0 and some lower fraction bit is 1. Quieting sets bit 22.

An operation is presented for one cycle with `op_valid` high. One cycle later the result appears on `res_word` with a one-cycle `res_valid` strobe. `res_invalid` shows whether that operation raised invalid. A sticky invalid flag collects every invalid event until `flag_clear` is asserted. Callers must send only operand pairs in which at least one operand is a NaN.

Top module: `nan_pick_unit`

## Requirements
- R1: Invalid is raised for an operation exactly when at least one operand is a signaling NaN (exponent bits 30:23 all ones, bit 22 = 0, bits 21:0 nonzero). It appears on `res_invalid` with the result.
- R2: `sticky_invalid` is the OR of all invalid events since the last clear. Once set, it stays set until `flag_clear`. When `flag_clear` is high, the flag becomes the invalid of any operation accepted in that same cycle, or 0 if there is none.
- R3: With `rule_sel` = 0 (and also 3), the result is a if a is signaling, else b if b is signaling, else a if a is quiet, else b.
- R4: With `rule_sel` = 1, the result is a whenever a is any NaN, otherwise b.
- R5: With `rule_sel` = 2, the result is chosen as follows:
  - Of two signaling NaNs, or of two quiet NaNs, the one with the larger significand wins.
  - A signaling NaN paired with a quiet NaN yields the quiet one.
  - Any NaN paired with a non-NaN yields the NaN.
- R6: Under `rule_sel` = 2, significands are compared as bits 30:0 of each word. On a tie, a wins when its full unsigned word is smaller, so the positive operand is chosen.
- R7: The chosen operand is always quieted by setting bit 22 before output. A quiet operand passes through unchanged.
- R8: When `dflt_mode` is high, the result is the parameter `DFLT_NAN` (default 32'h7FC00000). Invalid is still raised as in R1.
- R9: `res_valid` pulses high for one cycle, in the cycle after `op_valid` is sampled. `res_word` holds its last value between operations. After reset, `res_valid`, `res_word`, `res_invalid` and `sticky_invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rule_sel | input | 2 | Priority scheme: 0 and 3 signaling-first, 1 a-first, 2 magnitude |
| dflt_mode | input | 1 | Force the default NaN as the result |
| flag_clear | input | 1 | Synchronous clear of the sticky flag |
| res_valid | output | 1 | Result strobe |
| res_word | output | 32 | Selected, quieted NaN |
| res_invalid | output | 1 | Invalid raised by this operation |
| sticky_invalid | output | 1 | Accumulated invalid flag |

## Verification
Every result, per-operation flag and sticky-flag update is due exactly one clock edge after the cycle in which its inputs were sampled. The bench drives inputs on the falling edge. It waits for the next rising edge and samples one nanosecond later, before the next falling edge changes anything. Each check therefore looks at the single cycle in which the registered output reflects that stimulus and no later one. The hold of `res_word` and the one-cycle width of `res_valid` are checked one further cycle on, with `op_valid` low.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    typedef enum logic [1:0] {
        RULE_SIG_FIRST = 2'd0,
        RULE_A_FIRST   = 2'd1,
        RULE_MAGNITUDE = 2'd2,
        RULE_SPARE     = 2'd3
    } rule_e;

    typedef struct packed {
        logic is_q;
        logic is_s;
    } nan_cls_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
    import nanp_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 23
) (
    input  logic [W-1:0] word_i,
    output nan_cls_t     cls_o
);
    logic exp_ones;
    logic low_frac_nz;

    always_comb begin
        exp_ones    = &word_i[W-2:FRAC];
        low_frac_nz = |word_i[FRAC-2:0];
        cls_o.is_q  = exp_ones & word_i[FRAC-1];
        cls_o.is_s  = exp_ones & ~word_i[FRAC-1] & low_frac_nz;
    end

    always_comb begin
        assert (!(cls_o.is_q && cls_o.is_s)) else $error("AST_CLASS_EXCL"); // R1
    end
endmodule

// File: rtl/nanp_quiet.sv
module nanp_quiet
    import nanp_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 23
) (
    input  logic [W-1:0] word_i,
    input  nan_cls_t     cls_i,
    output logic [W-1:0] word_o
);
    localparam logic [W-1:0] QBIT = W'(1) << (FRAC - 1);

    always_comb begin
        word_o = cls_i.is_s ? (word_i | QBIT) : word_i;
    end
endmodule

// File: rtl/nanp_chooser.sv
module nanp_chooser
    import nanp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word_a_i,
    input  logic [W-1:0] word_b_i,
    input  nan_cls_t     cls_a_i,
    input  nan_cls_t     cls_b_i,
    input  rule_e        rule_i,
    output logic         pick_b_o
);
    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         a_larger;
    logic         a_nan;
    logic         b_nan;

    always_comb begin
        mag_a = word_a_i[W-2:0];
        mag_b = word_b_i[W-2:0];
        if (mag_a != mag_b) begin
            a_larger = (mag_a > mag_b);
        end else begin
            a_larger = (word_a_i < word_b_i);
        end
        a_nan = cls_a_i.is_q | cls_a_i.is_s;
        b_nan = cls_b_i.is_q | cls_b_i.is_s;
    end

    always_comb begin
        pick_b_o = 1'b0;
        unique case (rule_i)
            RULE_A_FIRST: begin
                pick_b_o = ~a_nan;
            end
            RULE_MAGNITUDE: begin
                if (cls_a_i.is_s) begin
                    if (cls_b_i.is_s) begin
                        pick_b_o = ~a_larger;
                    end else begin
                        pick_b_o = cls_b_i.is_q;
                    end
                end else if (cls_a_i.is_q) begin
                    if (cls_b_i.is_q) begin
                        pick_b_o = ~a_larger;
                    end else begin
                        pick_b_o = 1'b0;
                    end
                end else begin
                    pick_b_o = 1'b1;
                end
            end
            default: begin
                if (cls_a_i.is_s) begin
                    pick_b_o = 1'b0;
                end else if (cls_b_i.is_s) begin
                    pick_b_o = 1'b1;
                end else begin
                    pick_b_o = ~cls_a_i.is_q;
                end
            end
        endcase
    end

    always_comb begin
        if (rule_i == RULE_A_FIRST && a_nan) begin
            assert (!pick_b_o) else $error("AST_AFIRST_KEEPS_A"); // R4
        end
        if (rule_i == RULE_MAGNITUDE && a_nan && !b_nan) begin
            assert (!pick_b_o) else $error("AST_MAG_NAN_OVER_NUM"); // R5
        end
    end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
    import nanp_pkg::*;
#(
    parameter int          W        = 32,
    parameter int          FRAC     = 23,
    parameter logic [31:0] DFLT_NAN = 32'h7FC0_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [1:0]    rule_sel,
    input  logic          dflt_mode,
    input  logic          flag_clear,
    output logic          res_valid,
    output logic [W-1:0]  res_word,
    output logic          res_invalid,
    output logic          sticky_invalid
);
    localparam int NOPS = 2;
    localparam logic [W-1:0] DFLT_W = W'(DFLT_NAN);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] word;
        logic         inv;
        logic         sticky;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] opw     [NOPS];
    nan_cls_t     cls     [NOPS];
    logic         pick_b;
    logic [W-1:0] sel_word;
    nan_cls_t     sel_cls;
    logic [W-1:0] quiet_word;
    logic         any_snan;

    assign opw[0] = op_a;
    assign opw[1] = op_b;

    generate
        for (genvar i = 0; i < NOPS; i++) begin : g_cls
            nanp_classify #(.W(W), .FRAC(FRAC)) u_cls (
                .word_i (opw[i]),
                .cls_o  (cls[i])
            );
        end
    endgenerate

    nanp_chooser #(.W(W)) u_choose (
        .word_a_i (op_a),
        .word_b_i (op_b),
        .cls_a_i  (cls[0]),
        .cls_b_i  (cls[1]),
        .rule_i   (rule_e'(rule_sel)),
        .pick_b_o (pick_b)
    );

    always_comb begin
        sel_word = pick_b ? op_b   : op_a;
        sel_cls  = pick_b ? cls[1] : cls[0];
        any_snan = cls[0].is_s | cls[1].is_s;
    end

    nanp_quiet #(.W(W), .FRAC(FRAC)) u_quiet (
        .word_i (sel_word),
        .cls_i  (sel_cls),
        .word_o (quiet_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        if (flag_clear) begin
            st_d.sticky = 1'b0;
        end
        if (op_valid) begin
            st_d.inv    = any_snan;
            st_d.word   = dflt_mode ? DFLT_W : quiet_word;
            st_d.sticky = st_d.sticky | any_snan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid      = st_q.valid;
    assign res_word       = st_q.word;
    assign res_invalid    = st_q.inv;
    assign sticky_invalid = st_q.sticky;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_invalid && !flag_clear) |=> sticky_invalid); // R2
    AST_INV_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid && res_valid |-> sticky_invalid); // R2
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !op_valid) |=> !sticky_invalid); // R2
    AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (cls[0].is_s || cls[1].is_s)) |=> res_invalid); // R1
    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (&res_word[W-2:FRAC-1])); // R7
    AST_DFLT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dflt_mode) |=> (res_word == DFLT_W)); // R8
    AST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R9
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid); // R9
endmodule

// File: tb/sim_nan_pick_unit.sv
module sim_nan_pick_unit;
    localparam logic [31:0] QA  = 32'h7FC0_0001;
    localparam logic [31:0] QB  = 32'h7FC0_0002;
    localparam logic [31:0] SA  = 32'h7F80_0005;
    localparam logic [31:0] SAQ = 32'h7FC0_0005;
    localparam logic [31:0] SB  = 32'h7F80_0009;
    localparam logic [31:0] SBQ = 32'h7FC0_0009;
    localparam logic [31:0] NUM = 32'h3F80_0000;
    localparam logic [31:0] DEF = 32'h7FC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  rule_sel = '0;
    logic        dflt_mode = 1'b0;
    logic        flag_clear = 1'b0;
    logic        res_valid;
    logic [31:0] res_word;
    logic        res_invalid;
    logic        sticky_invalid;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    nan_pick_unit u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_a           (op_a),
        .op_b           (op_b),
        .rule_sel       (rule_sel),
        .dflt_mode      (dflt_mode),
        .flag_clear     (flag_clear),
        .res_valid      (res_valid),
        .res_word       (res_word),
        .res_invalid    (res_invalid),
        .sticky_invalid (sticky_invalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on falling edge, result registered at next rising edge, sample 1 ns later
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rs,
                         input logic dm, input logic clr);
        @(negedge clk);
        op_valid = 1'b1; op_a = a; op_b = b; rule_sel = rs; dflt_mode = dm; flag_clear = clr;
        @(posedge clk); #1;
        op_valid = 1'b0; flag_clear = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        flag_clear = 1'b1;
        @(posedge clk); #1;
        flag_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset valid",  32'(res_valid), 0);
        check("R9 reset word",   res_word, 0);
        check("R9 reset inv",    32'(res_invalid), 0);
        check("R2 reset sticky", 32'(sticky_invalid), 0);
    endtask

    task automatic t_rule0();
        do_op(QA, SB, 2'd0, 1'b0, 1'b0);
        check("R3 b signaling wins", res_word, SBQ);
        check("R1 invalid on sNaN b", 32'(res_invalid), 1);
        check("R9 strobe", 32'(res_valid), 1);
        @(posedge clk); #1;
        check("R9 strobe one cycle", 32'(res_valid), 0);
        check("R9 word holds", res_word, SBQ);
        do_op(SA, SB, 2'd0, 1'b0, 1'b0);
        check("R3 a signaling first", res_word, SAQ);
        do_op(QA, QB, 2'd0, 1'b0, 1'b0);
        check("R3 a quiet over b quiet", res_word, QA);
        check("R1 no invalid for quiet", 32'(res_invalid), 0);
        do_op(NUM, QB, 2'd0, 1'b0, 1'b0);
        check("R3 b when a not NaN", res_word, QB);
        do_op(QA, SB, 2'd3, 1'b0, 1'b0);
        check("R3 spare code acts as 0", res_word, SBQ);
    endtask

    task automatic t_rule1();
        do_op(QA, SB, 2'd1, 1'b0, 1'b0);
        check("R4 a quiet beats b signaling", res_word, QA);
        check("R1 invalid still raised", 32'(res_invalid), 1);
        do_op(NUM, SB, 2'd1, 1'b0, 1'b0);
        check("R4 b when a not NaN", res_word, SBQ);
        do_op(SA, QB, 2'd1, 1'b0, 1'b0);
        check("R7 a signaling quieted", res_word, SAQ);
    endtask

    task automatic t_rule2();
        do_op(SA, SB, 2'd2, 1'b0, 1'b0);
        check("R5 two sNaN larger sig", res_word, SBQ);
        do_op(SA, QB, 2'd2, 1'b0, 1'b0);
        check("R5 sNaN vs qNaN gives quiet", res_word, QB);
        do_op(SA, NUM, 2'd2, 1'b0, 1'b0);
        check("R5 sNaN vs number", res_word, SAQ);
        do_op(QA, NUM, 2'd2, 1'b0, 1'b0);
        check("R5 qNaN vs number", res_word, QA);
        do_op(QA, QB, 2'd2, 1'b0, 1'b0);
        check("R5 two qNaN larger sig", res_word, QB);
        do_op(32'hFFC0_0003, 32'h7FC0_0003, 2'd2, 1'b0, 1'b0);
        check("R6 tie picks positive b", res_word, 32'h7FC0_0003);
        do_op(32'h7FC0_0003, 32'hFFC0_0003, 2'd2, 1'b0, 1'b0);
        check("R6 tie picks positive a", res_word, 32'h7FC0_0003);
        do_op(32'hFFC0_0007, 32'h7FC0_0003, 2'd2, 1'b0, 1'b0);
        check("R6 sign ignored in size", res_word, 32'hFFC0_0007);
    endtask

    task automatic t_default();
        do_op(SA, QB, 2'd2, 1'b1, 1'b0);
        check("R8 default pattern", res_word, DEF);
        check("R8 invalid kept in default mode", 32'(res_invalid), 1);
        do_op(QA, QB, 2'd0, 1'b1, 1'b0);
        check("R8 default on quiet pair", res_word, DEF);
        check("R8 no invalid quiet pair", 32'(res_invalid), 0);
    endtask

    task automatic t_sticky();
        do_clear();
        check("R2 cleared", 32'(sticky_invalid), 0);
        do_op(QA, QB, 2'd0, 1'b0, 1'b0);
        check("R2 quiet keeps clear", 32'(sticky_invalid), 0);
        do_op(SA, NUM, 2'd0, 1'b0, 1'b0);
        check("R2 set by sNaN", 32'(sticky_invalid), 1);
        do_op(QA, QB, 2'd0, 1'b0, 1'b0);
        check("R2 stays set", 32'(sticky_invalid), 1);
        check("R1 later op own flag", 32'(res_invalid), 0);
        do_clear();
        check("R2 clear resets", 32'(sticky_invalid), 0);
        do_op(SA, QB, 2'd0, 1'b0, 1'b1);
        check("R2 clear with sNaN op sets", 32'(sticky_invalid), 1);
        do_op(QA, QB, 2'd0, 1'b0, 1'b1);
        check("R2 clear with quiet op", 32'(sticky_invalid), 0);
    endtask

    initial begin
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_rule0();
        t_rule1();
        t_rule2();
        t_default();
        t_sticky();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule